// File: doc/BRIEF.md
# Prefetch hint request handler

This block sits between a core pipeline and the level-one data cache. It takes one software prefetch hint at a time. A hint carries a kind (load intent, store intent or instruction prefetch), a target level, an address and two memory attributes: cacheable and shareable. For load and store hints the block queries the L1 data cache tags. On a miss to cacheable memory it sends one line fill request, either to the L1 fill port or to the L2 fill port. The request asks for shared or exclusive ownership and can ask that copies in other cores be invalidated.

The pipeline is told when the hint may retire. When a fill is needed, retirement happens as soon as the fill request is accepted downstream, and never waits for returning data. A hint that hits, or that names non-cacheable memory, retires one cycle after the tag response. An instruction prefetch hint is a no-op that retires in the cycle it is accepted.

The block holds at most one hint. Its ready output stays low from the moment a lookup-based hint is accepted until that hint retires.

Top module: `pref_hint_ctrl`

## Requirements
- R1: A hint of kind 2'b00 (load) or 2'b01 (store) is followed by a tag lookup. A fill request is raised only when the response reports a miss (`tag_hit_i`=0) and the hint's cacheable flag was set.
- R2: When a fill is needed, `retire_o` is high in exactly the cycle where the selected port's valid and ready are both high. `retire_o` is never high while a fill request is still waiting.
- R3: On a fill request, `*_fill_excl_o` is 0 for a load hint (shared fill) and 1 for a store hint (exclusive fill).
- R4: On a fill request, `*_fill_inv_o` is 1 exactly when the hint is a store hint and its shareable flag was set.
- R5: A hint with `hint_to_l2_i`=1 raises its fill only on the L2 port. A hint with `hint_to_l2_i`=0 raises its fill only on the L1 port. The two fill valids are never high together.
- R6: A hint of kind 2'b10 (instruction prefetch) or 2'b11 (reserved, handled the same way) raises no lookup and no fill. `retire_o` is high in its acceptance cycle.
- R7: A lookup-based hint whose response is a hit, or whose cacheable flag is clear, raises no fill. `retire_o` is high in the cycle after the response cycle.
- R8: `hint_ready_o` is high at reset and whenever no hint is pending. It is low from the cycle after a lookup-based hint is accepted until that hint has retired.
- R9: The fill address is the hint address with its low log2(LINE_BYTES) bits (6 bits for 64-byte lines) cleared.
- R10: `tag_req_o` rises in the cycle after acceptance and stays high until `tag_rsp_valid_i`. It carries the full hint address. A fill request that waits on ready keeps its valid high and its address and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hint_valid_i | input | 1 | Pipeline offers a hint |
| hint_ready_o | output | 1 | Block can take a hint |
| hint_kind_i | input | 2 | 00 load, 01 store, 10 instruction, 11 reserved no-op |
| hint_to_l2_i | input | 1 | Fill targets the L2 port |
| hint_addr_i | input | ADDR_W | Hint byte address |
| hint_cacheable_i | input | 1 | Address is cacheable |
| hint_shareable_i | input | 1 | Address is shareable |
| retire_o | output | 1 | Hint may retire this cycle |
| tag_req_o | output | 1 | Tag lookup request, held until response |
| tag_addr_o | output | ADDR_W | Lookup address |
| tag_rsp_valid_i | input | 1 | Lookup response present |
| tag_hit_i | input | 1 | Lookup hit |
| l1_fill_valid_o | output | 1 | L1 fill request valid |
| l1_fill_ready_i | input | 1 | L1 fill request accepted |
| l1_fill_addr_o | output | ADDR_W | L1 fill line address |
| l1_fill_excl_o | output | 1 | L1 fill wants exclusive ownership |
| l1_fill_inv_o | output | 1 | L1 fill invalidates other copies |
| l2_fill_valid_o | output | 1 | L2 fill request valid |
| l2_fill_ready_i | input | 1 | L2 fill request accepted |
| l2_fill_addr_o | output | ADDR_W | L2 fill line address |
| l2_fill_excl_o | output | 1 | L2 fill wants exclusive ownership |
| l2_fill_inv_o | output | 1 | L2 fill invalidates other copies |

## Verification
Several properties are checked on every cycle:
- the two fill valids never rise together;
- a waiting fill holds its address and flags;
- fill addresses are line aligned;
- the invalidate flag comes only with exclusive intent;
- retirement coincides with the fill handshake;
- ready stays low while a fill is outstanding.

Other behaviour depends on the hint that was accepted earlier, and only the bench's scenarios can show it: whether the correct port was chosen, whether a hit or a non-cacheable hint really skips the fill, the exact retire cycle after a delayed response, and the no-op path. The bench mixes random hints with random response and stall delays, and also runs directed corner cases.

// File: rtl/pfh_pkg.sv
package pfh_pkg;

  typedef enum logic [1:0] {
    HK_LOAD  = 2'b00,
    HK_STORE = 2'b01,
    HK_INSTR = 2'b10,
    HK_RSVD  = 2'b11
  } hint_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_FILL,
    ST_DONE
  } ctl_state_e;

  localparam int NUM_FILL_PORTS = 2;
  localparam int PORT_L1        = 0;
  localparam int PORT_L2        = 1;

  // instruction prefetch and the reserved code are both no-ops
  function automatic logic kind_is_nop(input logic [1:0] kind);
    return kind[1];
  endfunction

  function automatic logic kind_is_store(input logic [1:0] kind);
    return kind == HK_STORE;
  endfunction

  function automatic logic fill_needed(input logic hit, input logic cacheable);
    return !hit && cacheable;
  endfunction

  function automatic logic inval_others(input logic is_store, input logic shareable);
    return is_store && shareable;
  endfunction

endpackage

// File: rtl/pfh_capture.sv
module pfh_capture #(
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              is_store_i,
  input  logic              to_l2_i,
  input  logic              cacheable_i,
  input  logic              shareable_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic              is_store_q,
  output logic              to_l2_q,
  output logic              cacheable_q,
  output logic              shareable_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q      <= '0;
      is_store_q  <= 1'b0;
      to_l2_q     <= 1'b0;
      cacheable_q <= 1'b0;
      shareable_q <= 1'b0;
    end else if (load_i) begin
      addr_q      <= addr_i;
      is_store_q  <= is_store_i;
      to_l2_q     <= to_l2_i;
      cacheable_q <= cacheable_i;
      shareable_q <= shareable_i;
    end
  end

endmodule

// File: rtl/pfh_ctrl_fsm.sv
module pfh_ctrl_fsm
  import pfh_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hint_valid_i,
  input  logic nop_i,
  input  logic rsp_valid_i,
  input  logic need_fill_i,
  input  logic fill_accept_i,
  output logic hint_ready_o,
  output logic accept_o,
  output logic lookup_o,
  output logic fill_active_o,
  output logic retire_o
);

  ctl_state_e state_q, state_d;

  assign hint_ready_o  = (state_q == ST_IDLE);
  assign accept_o      = hint_ready_o && hint_valid_i;
  assign lookup_o      = (state_q == ST_LOOKUP);
  assign fill_active_o = (state_q == ST_FILL);
  assign retire_o      = (accept_o && nop_i)
                       || (state_q == ST_DONE)
                       || (fill_active_o && fill_accept_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept_o && !nop_i) state_d = ST_LOOKUP;
      ST_LOOKUP: if (rsp_valid_i) state_d = need_fill_i ? ST_FILL : ST_DONE;
      ST_FILL:   if (fill_accept_i) state_d = ST_IDLE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/pfh_fill_port.sv
module pfh_fill_port #(
  parameter int ADDR_W = 40
) (
  input  logic              active_i,
  input  logic              ready_i,
  input  logic [ADDR_W-1:0] line_addr_i,
  input  logic              excl_i,
  input  logic              inv_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              excl_o,
  output logic              inv_o,
  output logic              fire_o
);

  assign valid_o = active_i;
  assign addr_o  = active_i ? line_addr_i : '0;
  assign excl_o  = active_i && excl_i;
  assign inv_o   = active_i && inv_i;
  assign fire_o  = active_i && ready_i;

endmodule

// File: rtl/pref_hint_ctrl.sv
module pref_hint_ctrl
  import pfh_pkg::*;
#(
  parameter int ADDR_W     = 40,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hint_valid_i,
  output logic              hint_ready_o,
  input  logic [1:0]        hint_kind_i,
  input  logic              hint_to_l2_i,
  input  logic [ADDR_W-1:0] hint_addr_i,
  input  logic              hint_cacheable_i,
  input  logic              hint_shareable_i,
  output logic              retire_o,
  output logic              tag_req_o,
  output logic [ADDR_W-1:0] tag_addr_o,
  input  logic              tag_rsp_valid_i,
  input  logic              tag_hit_i,
  output logic              l1_fill_valid_o,
  input  logic              l1_fill_ready_i,
  output logic [ADDR_W-1:0] l1_fill_addr_o,
  output logic              l1_fill_excl_o,
  output logic              l1_fill_inv_o,
  output logic              l2_fill_valid_o,
  input  logic              l2_fill_ready_i,
  output logic [ADDR_W-1:0] l2_fill_addr_o,
  output logic              l2_fill_excl_o,
  output logic              l2_fill_inv_o
);

  localparam int OFF_W = $clog2(LINE_BYTES);

  function automatic logic [ADDR_W-1:0] line_base(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  endfunction

  // named internal events, visible to the bound checker
  logic              accept_w;
  logic              nop_hint_w;
  logic              need_fill_w;
  logic              fill_active_w;
  logic              fill_fire_w;
  logic [ADDR_W-1:0] addr_q;
  logic              is_store_q, to_l2_q, cacheable_q, shareable_q;

  logic [NUM_FILL_PORTS-1:0] p_valid, p_ready, p_excl, p_inv, p_fire;
  logic [ADDR_W-1:0]         p_addr [NUM_FILL_PORTS];

  assign nop_hint_w  = kind_is_nop(hint_kind_i);
  assign need_fill_w = fill_needed(tag_hit_i, cacheable_q);
  assign fill_fire_w = |p_fire;

  pfh_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (accept_w && !nop_hint_w),
    .addr_i      (hint_addr_i),
    .is_store_i  (kind_is_store(hint_kind_i)),
    .to_l2_i     (hint_to_l2_i),
    .cacheable_i (hint_cacheable_i),
    .shareable_i (hint_shareable_i),
    .addr_q      (addr_q),
    .is_store_q  (is_store_q),
    .to_l2_q     (to_l2_q),
    .cacheable_q (cacheable_q),
    .shareable_q (shareable_q)
  );

  pfh_ctrl_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .hint_valid_i  (hint_valid_i),
    .nop_i         (nop_hint_w),
    .rsp_valid_i   (tag_rsp_valid_i),
    .need_fill_i   (need_fill_w),
    .fill_accept_i (fill_fire_w),
    .hint_ready_o  (hint_ready_o),
    .accept_o      (accept_w),
    .lookup_o      (tag_req_o),
    .fill_active_o (fill_active_w),
    .retire_o      (retire_o)
  );

  assign tag_addr_o = addr_q;
  assign p_ready    = {l2_fill_ready_i, l1_fill_ready_i};

  for (genvar p = 0; p < NUM_FILL_PORTS; p++) begin : g_port
    logic sel;
    assign sel = (p == PORT_L2) ? to_l2_q : !to_l2_q;
    pfh_fill_port #(.ADDR_W(ADDR_W)) u_port (
      .active_i    (fill_active_w && sel),
      .ready_i     (p_ready[p]),
      .line_addr_i (line_base(addr_q)),
      .excl_i      (is_store_q),
      .inv_i       (inval_others(is_store_q, shareable_q)),
      .valid_o     (p_valid[p]),
      .addr_o      (p_addr[p]),
      .excl_o      (p_excl[p]),
      .inv_o       (p_inv[p]),
      .fire_o      (p_fire[p])
    );
  end

  assign l1_fill_valid_o = p_valid[PORT_L1];
  assign l1_fill_addr_o  = p_addr[PORT_L1];
  assign l1_fill_excl_o  = p_excl[PORT_L1];
  assign l1_fill_inv_o   = p_inv[PORT_L1];
  assign l2_fill_valid_o = p_valid[PORT_L2];
  assign l2_fill_addr_o  = p_addr[PORT_L2];
  assign l2_fill_excl_o  = p_excl[PORT_L2];
  assign l2_fill_inv_o   = p_inv[PORT_L2];

endmodule

// File: rtl/pfh_checker.sv
module pfh_checker #(
  parameter int ADDR_W     = 40,
  parameter int LINE_BYTES = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hint_ready_o,
  input logic              accept_w,
  input logic              nop_hint_w,
  input logic              retire_o,
  input logic              tag_req_o,
  input logic              tag_rsp_valid_i,
  input logic              l1_fill_valid_o,
  input logic              l1_fill_ready_i,
  input logic [ADDR_W-1:0] l1_fill_addr_o,
  input logic              l1_fill_excl_o,
  input logic              l1_fill_inv_o,
  input logic              l2_fill_valid_o,
  input logic              l2_fill_ready_i,
  input logic [ADDR_W-1:0] l2_fill_addr_o,
  input logic              l2_fill_excl_o,
  input logic              l2_fill_inv_o
);

  localparam int OFF_W = $clog2(LINE_BYTES);

  a_r5_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(l1_fill_valid_o && l2_fill_valid_o));

  a_r2_retire_at_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    ((l1_fill_valid_o && l1_fill_ready_i) || (l2_fill_valid_o && l2_fill_ready_i)) |-> retire_o);

  a_r2_no_retire_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    ((l1_fill_valid_o && !l1_fill_ready_i) || (l2_fill_valid_o && !l2_fill_ready_i)) |-> !retire_o);

  a_r8_busy_during_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_fill_valid_o || l2_fill_valid_o || tag_req_o) |-> !hint_ready_o);

  a_r9_l1_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    l1_fill_valid_o |-> (l1_fill_addr_o[OFF_W-1:0] == '0));

  a_r9_l2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    l2_fill_valid_o |-> (l2_fill_addr_o[OFF_W-1:0] == '0));

  a_r4_inv_needs_excl: assert property (@(posedge clk) disable iff (!rst_n)
    ((l1_fill_valid_o && l1_fill_inv_o) || (l2_fill_valid_o && l2_fill_inv_o))
      |-> (l1_fill_excl_o || l2_fill_excl_o));

  a_r10_l1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_fill_valid_o && !l1_fill_ready_i) |=>
      (l1_fill_valid_o && $stable(l1_fill_addr_o) && $stable(l1_fill_excl_o) && $stable(l1_fill_inv_o)));

  a_r10_l2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (l2_fill_valid_o && !l2_fill_ready_i) |=>
      (l2_fill_valid_o && $stable(l2_fill_addr_o) && $stable(l2_fill_excl_o) && $stable(l2_fill_inv_o)));

  a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_req_o && !tag_rsp_valid_i) |=> tag_req_o);

  a_r6_nop_retires: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && nop_hint_w) |-> retire_o);

  a_r6_nop_no_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && nop_hint_w) |=> (!tag_req_o && !l1_fill_valid_o && !l2_fill_valid_o));

endmodule

bind pref_hint_ctrl pfh_checker #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .hint_ready_o    (hint_ready_o),
  .accept_w        (accept_w),
  .nop_hint_w      (nop_hint_w),
  .retire_o        (retire_o),
  .tag_req_o       (tag_req_o),
  .tag_rsp_valid_i (tag_rsp_valid_i),
  .l1_fill_valid_o (l1_fill_valid_o),
  .l1_fill_ready_i (l1_fill_ready_i),
  .l1_fill_addr_o  (l1_fill_addr_o),
  .l1_fill_excl_o  (l1_fill_excl_o),
  .l1_fill_inv_o   (l1_fill_inv_o),
  .l2_fill_valid_o (l2_fill_valid_o),
  .l2_fill_ready_i (l2_fill_ready_i),
  .l2_fill_addr_o  (l2_fill_addr_o),
  .l2_fill_excl_o  (l2_fill_excl_o),
  .l2_fill_inv_o   (l2_fill_inv_o)
);

// File: tb/tb_pref_hint_ctrl.sv
module tb_pref_hint_ctrl;

  localparam int AW = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hint_valid_i = 1'b0;
  logic          hint_ready_o;
  logic [1:0]    hint_kind_i = '0;
  logic          hint_to_l2_i = 1'b0;
  logic [AW-1:0] hint_addr_i = '0;
  logic          hint_cacheable_i = 1'b0;
  logic          hint_shareable_i = 1'b0;
  logic          retire_o;
  logic          tag_req_o;
  logic [AW-1:0] tag_addr_o;
  logic          tag_rsp_valid_i = 1'b0;
  logic          tag_hit_i = 1'b0;
  logic          l1_fill_valid_o, l1_fill_ready_i = 1'b0;
  logic [AW-1:0] l1_fill_addr_o;
  logic          l1_fill_excl_o, l1_fill_inv_o;
  logic          l2_fill_valid_o, l2_fill_ready_i = 1'b0;
  logic [AW-1:0] l2_fill_addr_o;
  logic          l2_fill_excl_o, l2_fill_inv_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pref_hint_ctrl #(.ADDR_W(AW), .LINE_BYTES(64)) dut (.*);

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit m_fill(input logic [1:0] k, input bit hit, input bit c);
    return (k == 2'd0 || k == 2'd1) && !hit && c;
  endfunction
  function automatic bit m_excl(input logic [1:0] k);
    return k == 2'd1;
  endfunction
  function automatic bit m_inv(input logic [1:0] k, input bit s);
    return (k == 2'd1) && s;
  endfunction
  function automatic logic [AW-1:0] m_line(input logic [AW-1:0] a);
    return (a >> 6) << 6;
  endfunction

  task automatic run_hint(input logic [1:0] k, input bit l2, input logic [AW-1:0] a,
                          input bit c, input bit s, input bit hit,
                          input int rsp_dly, input int stall);
    bit f;
    logic [AW-1:0] la;
    f  = m_fill(k, hit, c);
    la = m_line(a);
    @(negedge clk);
    chk("R8", "ready when idle", hint_ready_o, 1);
    hint_valid_i = 1; hint_kind_i = k; hint_to_l2_i = l2; hint_addr_i = a;
    hint_cacheable_i = c; hint_shareable_i = s;
    l1_fill_ready_i = 0; l2_fill_ready_i = 0;
    #1;
    if (k[1]) chk("R6", "nop retires on accept", retire_o, 1);
    else      chk("R2", "no retire on accept", retire_o, 0);
    @(posedge clk);
    @(negedge clk);
    hint_valid_i = 0;
    hint_kind_i = $urandom; hint_addr_i = {$urandom, $urandom};
    #1;
    if (k[1]) begin
      chk("R6", "nop no lookup", tag_req_o, 0);
      chk("R6", "nop no fill", {l1_fill_valid_o, l2_fill_valid_o}, 0);
      chk("R6", "nop no second retire", retire_o, 0);
      return;
    end
    chk("R10", "lookup raised", tag_req_o, 1);
    chk("R10", "lookup address", tag_addr_o, a);
    chk("R8", "busy during lookup", hint_ready_o, 0);
    for (int i = 0; i < rsp_dly; i++) begin
      @(negedge clk); #1;
      chk("R10", "lookup held", tag_req_o, 1);
      chk("R7", "no early retire", retire_o, 0);
    end
    tag_rsp_valid_i = 1; tag_hit_i = hit;
    @(posedge clk);
    @(negedge clk);
    tag_rsp_valid_i = 0; tag_hit_i = $urandom;
    #1;
    chk("R10", "lookup dropped", tag_req_o, 0);
    if (!f) begin
      chk("R7", "retire after response", retire_o, 1);
      chk("R1", "no fill on hit/noncacheable", {l1_fill_valid_o, l2_fill_valid_o}, 0);
      @(negedge clk); #1;
      chk("R8", "ready after retire", hint_ready_o, 1);
      chk("R7", "single retire", retire_o, 0);
      return;
    end
    chk("R1", "fill raised on miss", l1_fill_valid_o | l2_fill_valid_o, 1);
    chk("R5", "port select", {l2_fill_valid_o, l1_fill_valid_o}, l2 ? 2'b10 : 2'b01);
    chk("R9", "line address", l2 ? l2_fill_addr_o : l1_fill_addr_o, la);
    chk("R3", "exclusive intent", l2 ? l2_fill_excl_o : l1_fill_excl_o, m_excl(k));
    chk("R4", "invalidate others", l2 ? l2_fill_inv_o : l1_fill_inv_o, m_inv(k, s));
    for (int i = 0; i < stall; i++) begin
      if (l2) l1_fill_ready_i = $urandom; else l2_fill_ready_i = $urandom;
      #0.5;
      chk("R2", "no retire while stalled", retire_o, 0);
      chk("R8", "busy while stalled", hint_ready_o, 0);
      @(negedge clk); #1;
      chk("R10", "held address", l2 ? l2_fill_addr_o : l1_fill_addr_o, la);
    end
    l1_fill_ready_i = !l2; l2_fill_ready_i = l2;
    #0.5;
    chk("R2", "retire at handshake", retire_o, 1);
    @(posedge clk);
    @(negedge clk);
    l1_fill_ready_i = 0; l2_fill_ready_i = 0;
    #1;
    chk("R2", "fill dropped", {l1_fill_valid_o, l2_fill_valid_o}, 0);
    chk("R8", "ready after fill", hint_ready_o, 1);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #1;
    chk("R8", "reset ready", hint_ready_o, 1);
    chk("R10", "reset lookup", tag_req_o, 0);
    chk("R5", "reset fills", {l1_fill_valid_o, l2_fill_valid_o}, 0);
    chk("R2", "reset retire", retire_o, 0);
    rst_n = 1;
    // directed corners
    run_hint(2'd0, 0, 40'h12_3456_78FF, 1, 1, 0, 0, 0); // load miss shareable: shared, no inv
    run_hint(2'd1, 0, 40'h00_0000_0041, 1, 1, 0, 2, 3); // store miss shareable: excl+inv
    run_hint(2'd1, 0, 40'hFF_FFFF_FFFF, 1, 0, 0, 0, 1); // store non-shareable
    run_hint(2'd1, 1, 40'hAB_CDEF_0123, 1, 1, 0, 1, 4); // store to L2
    run_hint(2'd0, 1, 40'h00_0000_003F, 1, 0, 0, 0, 0); // load to L2
    run_hint(2'd0, 0, 40'h55_5555_5555, 1, 0, 1, 3, 0); // hit
    run_hint(2'd1, 1, 40'h77_0000_1000, 0, 1, 0, 0, 0); // non-cacheable miss
    run_hint(2'd2, 0, 40'h10_0000_0000, 1, 1, 0, 0, 0); // instruction no-op
    run_hint(2'd3, 1, 40'h20_0000_0000, 1, 1, 0, 0, 0); // reserved no-op
    run_hint(2'd0, 0, 40'h01_0000_0080, 1, 0, 0, 0, 12); // long stall
    for (int n = 0; n < 300; n++)
      run_hint($urandom % 4, $urandom % 2, {$urandom, $urandom}, $urandom % 2,
               $urandom % 2, $urandom % 2, $urandom % 4, $urandom % 4);
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule